// File: doc/BRIEF.md
# Wide-Bank Cartridge Mapper

This block sits between a handheld CPU bus and the external ROM and RAM devices of a cartridge. It watches CPU writes into the lower half of the address map and turns them into bank settings, then translates every CPU access into a physical device address with a chip-select. The ROM bank number is nine bits wide. Its low eight bits and its ninth bit are loaded by writes to two different address ranges. The RAM bank number is four bits wide and is loaded from a third range. A fourth range carries a key value that arms or disarms the RAM.

The fixed ROM window at 0x0000-0x3FFF always shows bank 0. The switchable ROM window at 0x4000-0x7FFF shows the selected bank, and bank 0 may be selected there; it is not replaced by bank 1. The 8 KB RAM window at 0xA000-0xBFFF shows the selected RAM bank. Chip-selects are suppressed when the selected bank lies beyond the memory fitted, which is set by parameters. One build variant drives a vibration motor. In that variant bit 3 of the RAM bank write goes to the motor output and only the lower three bits pick the RAM bank. The memory arrays themselves lie outside the block.

Top module: `wide_bank_mapper`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, RAM is disarmed and the motor output is low.
- R2: A CPU write to 0x2000-0x2FFF loads the whole data byte into ROM bank bits 7:0 and leaves ROM bank bit 8 unchanged.
- R3: A CPU write to 0x3000-0x3FFF loads data bit 0 into ROM bank bit 8 and leaves ROM bank bits 7:0 unchanged.
- R4: A ROM bank value of 0 stays 0: a read in 0x4000-0x7FFF then yields a ROM address equal to the CPU address minus 0x4000.
- R5: `romAddr` is {9'd0, cpuAddr[13:0]} when cpuAddr[14] is 0 and {romBank, cpuAddr[13:0]} when cpuAddr[14] is 1. `romCs` is high only for a read (`cpuRd`) with cpuAddr below 0x8000.
- R6: A CPU write to 0x4000-0x5FFF loads the RAM bank. With HAS_MOTOR=1, data bit 3 drives `motorOn` and data bits 2:0 form the bank, with bank bit 3 held at 0. With HAS_MOTOR=0, data bits 3:0 form the bank and `motorOn` stays 0.
- R7: A CPU write to 0x0000-0x1FFF arms RAM when data bits 3:0 equal 0xA, whatever the upper nibble holds. Any other value disarms it.
- R8: `ramAddr` is {ramBank, cpuAddr[12:0]}. `ramCs` is high for a read or a write in 0xA000-0xBFFF while RAM is armed, and `ramWe` is high when `ramCs` is high and `cpuWr` is high.
- R9: `romCs` stays low when the effective ROM bank is ROM_BANKS or higher. `ramCs` stays low when the RAM bank is RAM_BANKS or higher.
- R10: Writes to 0x6000-0x7FFF, writes at or above 0x8000, and reads anywhere change no bank, arm or motor state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWr | input | 1 | CPU write strobe |
| cpuRd | input | 1 | CPU read strobe |
| romAddr | output | 23 | Physical ROM byte address |
| romCs | output | 1 | ROM chip-select |
| ramAddr | output | 17 | Physical RAM byte address |
| ramCs | output | 1 | RAM chip-select |
| ramWe | output | 1 | RAM write enable |
| motorOn | output | 1 | Vibration motor drive |

## Verification
Directed patterns first load the low byte and the ninth bit separately. This shows that each range keeps the other part of the bank. Selecting bank 0 then separates a design that remaps zero from one that does not. Banks just inside and just past the fitted size, on both the low byte and the ninth bit, check the suppression boundary. Arm keys with a nonzero upper nibble and a near-miss nibble check how the key is compared. A RAM bank write with bit 3 set checks that the motor bit is split off from the bank. Writes to the unused range and reads of control ranges show that these leave the state alone. A long run of mixed random accesses is then compared cycle by cycle with a behavioural model.

// File: rtl/wide_bank_pkg.sv
package wide_bank_pkg;
  localparam int ROM_BANK_W = 9;
  localparam int RAM_BANK_W = 4;
  localparam int ROM_OFS_W  = 14;
  localparam int RAM_OFS_W  = 13;
  localparam int ROM_ADDR_W = ROM_BANK_W + ROM_OFS_W;
  localparam int RAM_ADDR_W = RAM_BANK_W + RAM_OFS_W;

  typedef struct packed {
    logic       ldRomLo;
    logic       ldRomHi;
    logic       ldRamSel;
    logic       ldArm;
    logic [7:0] value;
  } bankStrobe_t;
endpackage

// File: rtl/wide_bank_ctrl.sv
module wide_bank_ctrl
  import wide_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuData,
  input  logic        cpuWr,
  output bankStrobe_t strobe
);
  logic ctrlSpace;
  logic [2:0] region;

  assign ctrlSpace = cpuWr && !cpuAddr[15];
  assign region    = cpuAddr[14:12];

  always_comb begin
    strobe          = '0;
    strobe.value    = cpuData;
    if (ctrlSpace) begin
      unique case (region)
        3'b000, 3'b001: strobe.ldArm    = 1'b1;
        3'b010:         strobe.ldRomLo  = 1'b1;
        3'b011:         strobe.ldRomHi  = 1'b1;
        3'b100, 3'b101: strobe.ldRamSel = 1'b1;
        default:        ;
      endcase
    end
  end

  // R10: at most one register load per cycle, none without a write
  p_one_load_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.ldRomLo, strobe.ldRomHi, strobe.ldRamSel, strobe.ldArm}));
  p_no_load_on_read_r10: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWr |-> !(strobe.ldRomLo || strobe.ldRomHi || strobe.ldRamSel || strobe.ldArm));
endmodule

// File: rtl/wide_bank_datapath.sv
module wide_bank_datapath
  import wide_bank_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  parameter bit HAS_MOTOR = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  bankStrobe_t           strobe,
  input  logic [15:0]           cpuAddr,
  input  logic                  cpuWr,
  input  logic                  cpuRd,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic                  romCs,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramCs,
  output logic                  ramWe,
  output logic                  motorOn
);
  logic [ROM_BANK_W-1:0] romBank;
  logic [RAM_BANK_W-1:0] ramBank;
  logic                  ramArmed;
  logic                  motorQ;
  logic [RAM_BANK_W-1:0] ramBankNext;
  logic                  motorNext;
  logic [ROM_BANK_W-1:0] effRomBank;
  logic                  romFits;
  logic                  ramFits;
  logic                  inRamWin;

  generate
    if (HAS_MOTOR) begin : g_motor
      assign ramBankNext = {1'b0, strobe.value[2:0]};
      assign motorNext   = strobe.value[3];
    end else begin : g_plain
      assign ramBankNext = strobe.value[RAM_BANK_W-1:0];
      assign motorNext   = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      romBank  <= ROM_BANK_W'(1);
      ramBank  <= '0;
      ramArmed <= 1'b0;
      motorQ   <= 1'b0;
    end else begin
      if (strobe.ldRomLo) romBank[7:0] <= strobe.value;
      if (strobe.ldRomHi) romBank[8]   <= strobe.value[0];
      if (strobe.ldRamSel) begin
        ramBank <= ramBankNext;
        motorQ  <= motorNext;
      end
      if (strobe.ldArm) ramArmed <= (strobe.value[3:0] == 4'hA);
    end
  end

  assign effRomBank = cpuAddr[14] ? romBank : '0;
  assign romAddr    = {effRomBank, cpuAddr[ROM_OFS_W-1:0]};
  assign romFits    = (32'(effRomBank) < ROM_BANKS);
  assign romCs      = cpuRd && !cpuAddr[15] && romFits;

  assign inRamWin   = (cpuAddr[15:13] == 3'b101);
  assign ramAddr    = {ramBank, cpuAddr[RAM_OFS_W-1:0]};
  assign ramFits    = (32'(ramBank) < RAM_BANKS);
  assign ramCs      = (cpuRd || cpuWr) && inRamWin && ramArmed && ramFits;
  assign ramWe      = ramCs && cpuWr;
  assign motorOn    = motorQ;

  p_lo_keeps_hi_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldRomLo && !strobe.ldRomHi) |=> romBank[8] == $past(romBank[8]));
  p_hi_keeps_lo_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldRomHi && !strobe.ldRomLo) |=> romBank[7:0] == $past(romBank[7:0]));
  p_zero_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ldRomLo && strobe.value == 8'h00 && !romBank[8]) |=> romBank == '0);
  p_arm_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldArm |=> $stable(ramArmed));
  p_ram_sel_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ldRamSel |=> ($stable(ramBank) && $stable(motorQ)));
  p_rom_cs_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    romCs |-> (cpuRd && romAddr < ROM_ADDR_W'(ROM_BANKS) * ROM_ADDR_W'(16384)));
  p_we_needs_cs_r8: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (ramCs && cpuWr));
  p_motor_bank_split_r6: assert property (@(posedge clk) disable iff (!rstN)
    HAS_MOTOR |-> !ramBank[RAM_BANK_W-1]);
endmodule

// File: rtl/wide_bank_mapper.sv
module wide_bank_mapper
  import wide_bank_pkg::*;
#(
  parameter int ROM_BANKS = 64,
  parameter int RAM_BANKS = 4,
  parameter bit HAS_MOTOR = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [15:0]           cpuAddr,
  input  logic [7:0]            cpuData,
  input  logic                  cpuWr,
  input  logic                  cpuRd,
  output logic [ROM_ADDR_W-1:0] romAddr,
  output logic                  romCs,
  output logic [RAM_ADDR_W-1:0] ramAddr,
  output logic                  ramCs,
  output logic                  ramWe,
  output logic                  motorOn
);
  bankStrobe_t strobe;

  wide_bank_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .cpuWr   (cpuWr),
    .strobe  (strobe)
  );

  wide_bank_datapath #(
    .ROM_BANKS (ROM_BANKS),
    .RAM_BANKS (RAM_BANKS),
    .HAS_MOTOR (HAS_MOTOR)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .cpuAddr (cpuAddr),
    .cpuWr   (cpuWr),
    .cpuRd   (cpuRd),
    .romAddr (romAddr),
    .romCs   (romCs),
    .ramAddr (ramAddr),
    .ramCs   (ramCs),
    .ramWe   (ramWe),
    .motorOn (motorOn)
  );
endmodule

// File: tb/test_wide_bank_mapper.sv
`timescale 1ns/1ps
module test_wide_bank_mapper;
  localparam int ROM_BANKS = 64;
  localparam int RAM_BANKS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0]  cpuData = '0;
  logic        cpuWr = 1'b0;
  logic        cpuRd = 1'b0;
  logic [22:0] romAddr;
  logic        romCs;
  logic [16:0] ramAddr;
  logic        ramCs;
  logic        ramWe;
  logic        motorOn;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int mRom, mRam, mArm, mMotor;

  wide_bank_mapper #(.ROM_BANKS(ROM_BANKS), .RAM_BANKS(RAM_BANKS), .HAS_MOTOR(1'b1))
    i_wide_bank_mapper (.*);

  always #4 clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    int a, effBank, expRom, expRomCs, expRamCs, inWin;
    a = int'(cpuAddr);
    effBank  = ((a >> 14) & 1) ? mRom : 0;
    expRom   = (effBank << 14) | (a & 16'h3FFF);
    expRomCs = (cpuRd && a < 16'h8000 && effBank < ROM_BANKS) ? 1 : 0;
    inWin    = (a >= 16'hA000 && a <= 16'hBFFF) ? 1 : 0;
    expRamCs = ((cpuRd || cpuWr) && inWin && mArm == 1 && mRam < RAM_BANKS) ? 1 : 0;
    check({req, " R5"}, "romAddr", int'(romAddr), expRom);
    check({req, " R9"}, "romCs", int'(romCs), expRomCs);
    check({req, " R8"}, "ramAddr", int'(ramAddr), (mRam << 13) | (a & 16'h1FFF));
    check({req, " R8"}, "ramCs", int'(ramCs), expRamCs);
    check({req, " R8"}, "ramWe", int'(ramWe), (expRamCs && cpuWr) ? 1 : 0);
    check({req, " R6"}, "motorOn", int'(motorOn), mMotor);
  endtask

  task automatic modelUpdate(int a, int d, bit w);
    if (!w) return;
    if (a < 16'h2000) mArm = ((d & 15) == 10) ? 1 : 0;
    else if (a < 16'h3000) mRom = (mRom & 256) | (d & 255);
    else if (a < 16'h4000) mRom = (mRom & 255) | ((d & 1) << 8);
    else if (a < 16'h6000) begin mMotor = (d >> 3) & 1; mRam = d & 7; end
  endtask

  task automatic apply(string req, int a, int d, bit w, bit r);
    @(negedge clk);
    cpuAddr = 16'(a); cpuData = 8'(d); cpuWr = w; cpuRd = r;
    #1;
    compare(req);
    @(posedge clk);
    modelUpdate(a, d, w);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    mRom = 1; mRam = 0; mArm = 0; mMotor = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state seen through the windows
    apply("R1", 16'h4000, 0, 0, 1);
    apply("R1", 16'hA000, 0, 0, 1);
    apply("R5", 16'h1234, 0, 0, 1);
    // R2: low byte load keeps bit 8
    apply("R2", 16'h2000, 8'h05, 1, 0);
    apply("R2", 16'h4123, 0, 0, 1);
    // R3: ninth bit load keeps low byte; bank 0x105 out of range (R9)
    apply("R3", 16'h3FFF, 8'h3F, 1, 0);
    apply("R9", 16'h7FFF, 0, 0, 1);
    apply("R2", 16'h2ABC, 8'h00, 1, 0);
    apply("R9", 16'h4000, 0, 0, 1);
    apply("R3", 16'h3000, 8'hFE, 1, 0);
    // R4: bank 0 stays 0 in the switchable window
    apply("R4", 16'h4000, 0, 0, 1);
    apply("R4", 16'h5555, 0, 0, 1);
    // R9: boundary banks 63 and 64
    apply("R9", 16'h2000, 8'h3F, 1, 0);
    apply("R9", 16'h7000, 0, 0, 1);
    apply("R9", 16'h2000, 8'h40, 1, 0);
    apply("R9", 16'h6000, 0, 0, 1);
    apply("R5", 16'h0100, 0, 0, 1);
    // R7: arming keys
    apply("R7", 16'hA010, 0, 1, 0);
    apply("R7", 16'h1000, 8'hFA, 1, 0);
    apply("R7", 16'hA010, 0, 0, 1);
    apply("R7", 16'h0000, 8'hAB, 1, 0);
    apply("R7", 16'hB000, 0, 0, 1);
    apply("R7", 16'h1FFF, 8'h0A, 1, 0);
    // R6: motor bit split from the bank
    apply("R6", 16'h4000, 8'h0B, 1, 0);
    apply("R8", 16'hBFFF, 8'h77, 1, 0);
    apply("R8", 16'hA001, 0, 0, 1);
    apply("R6", 16'h5FFF, 8'h0D, 1, 0);
    apply("R9", 16'hA200, 0, 0, 1);
    apply("R6", 16'h4800, 8'h02, 1, 0);
    // R10: unused range and reads leave state alone
    apply("R10", 16'h6000, 8'hFF, 1, 0);
    apply("R10", 16'h2000, 0, 0, 1);
    apply("R10", 16'h0000, 0, 0, 1);
    apply("R10", 16'hC000, 8'h55, 1, 0);
    apply("R10", 16'hA123, 0, 0, 1);
    apply("R10", 16'h4000, 0, 0, 1);
    // mixed random accesses
    for (int i = 0; i < 600; i++) begin
      int a, d, sel;
      sel = int'($urandom_range(0, 7));
      d = int'($urandom_range(0, 255));
      case (sel)
        0: a = int'($urandom_range(16'h0000, 16'h1FFF));
        1: a = int'($urandom_range(16'h2000, 16'h3FFF));
        2: a = int'($urandom_range(16'h4000, 16'h5FFF));
        3: a = int'($urandom_range(16'h6000, 16'h7FFF));
        4, 5: a = int'($urandom_range(16'hA000, 16'hBFFF));
        default: a = int'($urandom_range(0, 16'hFFFF));
      endcase
      if (sel == 1 && d[1]) d = d & 8'h3F;
      apply("R10", a, d, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule